// File: doc/BRIEF.md
# SDRAM Burst Data Path with Byte Masking

This block models the data side of a synchronous DRAM device on a small internal array. A command names read or write, a bank, a starting column and an auto-precharge flag. From there the block walks the burst through the columns, one column per clock. The row is taken as already open.

Writes take data from `dq_in` in the same cycles as the column accesses, starting with the command cycle. For each write beat, the mask input sampled in that same cycle decides whether the beat is stored. Reads return data `CL` clocks after each column access. For each read beat, the mask sampled two clocks before the beat is driven decides whether the output enable is raised. A read or write with the auto-precharge flag set produces a one-cycle precharge request for its bank once the last column of the burst has been accessed. Any new command cuts off a burst that is still in progress.

Top module: `sdram_burst_dp`

## Requirements
- R1: A write command sampled at clock edge n stores the `dq_in` value sampled at edge n+k as beat k, for k = 0 to BL-1.
- R2: Beat k uses the column formed from the start column by replacing its low log2(BL) bits with (start + k) mod BL. The upper column bits and the bank stay fixed for the whole burst.
- R3: During a write beat, `dqm` = 1 at that beat's edge discards the beat and leaves the addressed location unchanged. `dqm` = 0 stores it.
- R4: For a read command sampled at edge n, beat k carries the current content of its location on `dq_out`, with `dq_oe` = 1, in the cycle after edge n+CL+k.
- R5: A read beat k is suppressed (`dq_oe` = 0) when `dqm` sampled at edge n+CL+k-2 is 1. The mask is taken two edges before the edge that drives the beat.
- R6: In every cycle that carries no unmasked read beat, including the cycles after reset, `dq_oe` = 0 and `dq_out` is all zeros.
- R7: A command with `cmd_ap` = 1 raises `pre_req` for exactly one cycle, the cycle after the edge of its last column access (n+BL-1), with `pre_bank` equal to its bank. A command with `cmd_ap` = 0 never raises `pre_req`.
- R8: A command sampled while a burst is in progress ends that burst. Its remaining column accesses are not made and its precharge request is dropped. Read beats that were already accessed still appear as in R4.
- R9: Each bank holds its own COLS locations. A write to one bank never changes what a read from another bank returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Command present this cycle |
| cmd_wr | input | 1 | 1 = write burst, 0 = read burst |
| cmd_bank | input | $clog2(BANKS) | Bank of the command |
| cmd_col | input | $clog2(COLS) | Starting column |
| cmd_ap | input | 1 | Request precharge at the end of the burst |
| dqm | input | 1 | Data mask (write: same cycle; read: two cycles ahead) |
| dq_in | input | DW | Write data |
| dq_out | output | DW | Read data, zero when not driven |
| dq_oe | output | 1 | Read data output enable |
| pre_req | output | 1 | One-cycle precharge request |
| pre_bank | output | $clog2(BANKS) | Bank for the precharge request |

## Verification
The bench builds the block with 4 banks of 16 byte-wide columns, a burst length of 4 and a CAS latency of 3 rather than the default of 2. With a latency of 3, the read mask for the first beat is sampled one edge after the command instead of on the command edge. This separates the read mask timing from the command timing and from the write mask timing. The burst length of 4 makes start columns in the middle of a 4-column block reachable, so the wrap-around order is exercised. It also leaves enough beats to interrupt a burst after two of them.

// File: rtl/sdram_dp_pkg.sv
`timescale 1ns/1ps
package sdram_dp_pkg;
  // Kind of column access made in a given cycle
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/sdram_burst_seq.sv
`timescale 1ns/1ps
// Burst sequencer: one column access per cycle, wrapped inside a BL block
module sdram_burst_seq
  import sdram_dp_pkg::*;
#(
  parameter int BAW = 2,
  parameter int CAW = 4,
  parameter int BL  = 4,
  localparam int KW = (BL > 1) ? $clog2(BL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_vld,
  input  logic            cmd_wr,
  input  logic [BAW-1:0]  cmd_bank,
  input  logic [CAW-1:0]  cmd_col,
  input  logic            cmd_ap,
  output acc_kind_e       acc_kind,
  output logic [BAW-1:0]  acc_bank,
  output logic [CAW-1:0]  acc_col,
  output logic            busy,
  output logic [KW-1:0]   idx,
  output logic            pre_req,
  output logic [BAW-1:0]  pre_bank
);
  localparam logic [CAW-1:0] WRAP_MASK = CAW'(BL - 1);
  localparam logic [KW-1:0]  LAST_BEAT = KW'(BL - 1);

  // control state (reset)
  logic           act_q, act_d;
  logic [KW-1:0]  cnt_q, cnt_d;
  logic           pre_q, pre_d;
  logic [BAW-1:0] preb_q, preb_d;
  // burst fields (datapath, no reset)
  logic           wr_q, ap_q;
  logic [BAW-1:0] bank_q;
  logic [CAW-1:0] start_q;

  logic           s_wr, s_ap, s_valid, s_last;
  logic [BAW-1:0] s_bank;
  logic [CAW-1:0] s_start;
  logic [KW-1:0]  s_k;

  always_comb begin
    if (cmd_vld) begin
      s_wr    = cmd_wr;
      s_ap    = cmd_ap;
      s_bank  = cmd_bank;
      s_start = cmd_col;
      s_k     = '0;
    end else begin
      s_wr    = wr_q;
      s_ap    = ap_q;
      s_bank  = bank_q;
      s_start = start_q;
      s_k     = cnt_q;
    end
    s_valid = cmd_vld | act_q;
    s_last  = s_valid && (s_k == LAST_BEAT);

    acc_bank = s_bank;
    acc_col  = (s_start & ~WRAP_MASK) | ((s_start + CAW'(s_k)) & WRAP_MASK);
    if (!s_valid)  acc_kind = ACC_NONE;
    else if (s_wr) acc_kind = ACC_WR;
    else           acc_kind = ACC_RD;

    act_d  = act_q;
    cnt_d  = cnt_q;
    if (s_valid) begin
      act_d = ~s_last;
      cnt_d = s_k + KW'(1);
    end
    pre_d  = s_last & s_ap;
    preb_d = s_bank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      pre_q  <= 1'b0;
      preb_q <= '0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      pre_q  <= pre_d;
      preb_q <= preb_d;
    end
  end

  // capture burst fields only when a command arrives
  always_ff @(posedge clk) begin
    if (cmd_vld) begin
      wr_q    <= cmd_wr;
      ap_q    <= cmd_ap;
      bank_q  <= cmd_bank;
      start_q <= cmd_col;
    end
  end

  assign busy     = act_q;
  assign idx      = cnt_q;
  assign pre_req  = pre_q;
  assign pre_bank = preb_q;
endmodule

// File: rtl/sdram_cell_array.sv
`timescale 1ns/1ps
// Small storage array, one access per cycle, asynchronous read
module sdram_cell_array #(
  parameter int DW    = 8,
  parameter int AW    = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/sdram_rd_pipe.sv
`timescale 1ns/1ps
// Read latency pipeline with a two-cycle mask delay at the output stage
module sdram_rd_pipe #(
  parameter int DW = 8,
  parameter int CL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [DW-1:0] rdata,
  input  logic          dqm,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  logic [CL-1:0] vld_q, vld_d;
  logic [DW-1:0] dat_q [CL];
  logic          m1_q, m2_q;
  logic          oe_q, oe_d;
  logic [DW-1:0] out_q, out_d;

  always_comb begin
    vld_d = {vld_q[CL-2:0], issue};
    oe_d  = vld_q[CL-1] & ~m2_q;
    out_d = oe_d ? dat_q[CL-1] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      m1_q  <= 1'b0;
      m2_q  <= 1'b0;
      oe_q  <= 1'b0;
      out_q <= '0;
    end else begin
      vld_q <= vld_d;
      m1_q  <= dqm;
      m2_q  <= m1_q;
      oe_q  <= oe_d;
      out_q <= out_d;
    end
  end

  // data shift register, no reset needed
  always_ff @(posedge clk) begin
    dat_q[0] <= rdata;
    for (int i = 1; i < CL; i++) dat_q[i] <= dat_q[i-1];
  end

  assign dq_out = out_q;
  assign dq_oe  = oe_q;
endmodule

// File: rtl/sdram_burst_dp.sv
`timescale 1ns/1ps
// Top: device-side burst data path of a small SDRAM model
module sdram_burst_dp
  import sdram_dp_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int COLS  = 16,
  parameter int DW    = 8,
  parameter int BL    = 4,
  parameter int CL    = 2,
  localparam int BAW  = $clog2(BANKS),
  localparam int CAW  = $clog2(COLS),
  localparam int KW   = (BL > 1) ? $clog2(BL) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_vld,
  input  logic           cmd_wr,
  input  logic [BAW-1:0] cmd_bank,
  input  logic [CAW-1:0] cmd_col,
  input  logic           cmd_ap,
  input  logic           dqm,
  input  logic [DW-1:0]  dq_in,
  output logic [DW-1:0]  dq_out,
  output logic           dq_oe,
  output logic           pre_req,
  output logic [BAW-1:0] pre_bank
);
  acc_kind_e      acc_kind;
  logic [BAW-1:0] acc_bank;
  logic [CAW-1:0] acc_col;
  logic           seq_busy;
  logic [KW-1:0]  seq_idx;
  logic           mem_we, rd_issue;
  logic [DW-1:0]  mem_rdata;

  sdram_burst_seq #(.BAW(BAW), .CAW(CAW), .BL(BL)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_vld  (cmd_vld),
    .cmd_wr   (cmd_wr),
    .cmd_bank (cmd_bank),
    .cmd_col  (cmd_col),
    .cmd_ap   (cmd_ap),
    .acc_kind (acc_kind),
    .acc_bank (acc_bank),
    .acc_col  (acc_col),
    .busy     (seq_busy),
    .idx      (seq_idx),
    .pre_req  (pre_req),
    .pre_bank (pre_bank)
  );

  // write mask is applied in the same cycle as the data
  assign mem_we   = (acc_kind == ACC_WR) && !dqm;
  assign rd_issue = (acc_kind == ACC_RD);

  sdram_cell_array #(.DW(DW), .AW(BAW + CAW)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .addr  ({acc_bank, acc_col}),
    .wdata (dq_in),
    .rdata (mem_rdata)
  );

  sdram_rd_pipe #(.DW(DW), .CL(CL)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue  (rd_issue),
    .rdata  (mem_rdata),
    .dqm    (dqm),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
  );
endmodule

// File: rtl/sdram_dp_chk.sv
`timescale 1ns/1ps
// Property checker, attached to the top by bind
module sdram_dp_chk #(
  parameter int DW = 8,
  parameter int BL = 4,
  parameter int KW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_vld,
  input logic          cmd_ap,
  input logic          dqm,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe,
  input logic          pre_req,
  input logic          seq_busy,
  input logic [KW-1:0] seq_idx
);
  // R5: an enabled read beat needs dqm low three samples back
  a_r5_read_mask: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !$past(dqm, 3));

  // R6: bus is zero whenever the output enable is off
  a_r6_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));

  // R7: a precharge request follows the end of an uninterrupted burst
  a_r7_pre_source: assert property (@(posedge clk) disable iff (!rst_n)
    pre_req |-> ((BL == 1) ? $past(cmd_vld && cmd_ap) : !$past(cmd_vld)));

  // R8: any command restarts the beat count
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> ((BL == 1) ? !seq_busy : (seq_busy && (seq_idx == KW'(1)))));

  // R1: a burst in progress never sits at beat zero
  a_r1_busy_idx: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> (seq_idx != '0));
endmodule

bind sdram_burst_dp sdram_dp_chk #(.DW(DW), .BL(BL), .KW(KW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_vld  (cmd_vld),
  .cmd_ap   (cmd_ap),
  .dqm      (dqm),
  .dq_out   (dq_out),
  .dq_oe    (dq_oe),
  .pre_req  (pre_req),
  .seq_busy (seq_busy),
  .seq_idx  (seq_idx)
);

// File: tb/tb_sdram_burst_dp.sv
`timescale 1ns/1ps
module tb_sdram_burst_dp;
  localparam int BANKS = 4;
  localparam int COLS  = 16;
  localparam int DW    = 8;
  localparam int BL    = 4;
  localparam int CL    = 3;
  localparam int BAW   = $clog2(BANKS);
  localparam int CAW   = $clog2(COLS);
  localparam int HN    = 8192;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           cmd_vld, cmd_wr, cmd_ap, dqm;
  logic [BAW-1:0] cmd_bank;
  logic [CAW-1:0] cmd_col;
  logic [DW-1:0]  dq_in, dq_out;
  logic           dq_oe, pre_req;
  logic [BAW-1:0] pre_bank;

  always #2.5 clk = ~clk;

  sdram_burst_dp #(.BANKS(BANKS), .COLS(COLS), .DW(DW), .BL(BL), .CL(CL)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap), .dqm(dqm),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .pre_req(pre_req),
    .pre_bank(pre_bank)
  );

  typedef struct { int due; int val; } ev_t;
  ev_t   rq[$];
  ev_t   pq[$];
  int    ref_m [BANKS*COLS];
  bit    dqm_hist [HN];
  int    cyc = 0;
  int    n_chk = 0, n_bad = 0;
  bit    mon_on = 0;
  string phase = "R6";

  bit b_act = 0, b_wr = 0, b_ap = 0;
  int b_bank = 0, b_start = 0, b_k = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [phase %s] cycle=%0d actual=%0d expected=%0d", req, phase, cyc, act, exp);
    end
  endtask

  // driver: one clock edge of stimulus, with reference model update
  task automatic step(bit v, bit wr, int bank, int col, bit ap, bit m, int d);
    int e, k, c, idx;
    bit acc;
    @(negedge clk);
    cmd_vld = v; cmd_wr = wr; cmd_bank = BAW'(bank); cmd_col = CAW'(col);
    cmd_ap = ap; dqm = m; dq_in = DW'(d);
    e = cyc + 1;
    dqm_hist[e % HN] = m;
    acc = 0; k = 0;
    if (v) begin
      b_wr = wr; b_bank = bank; b_start = col; b_ap = ap; k = 0; acc = 1;
    end else if (b_act) begin
      k = b_k; acc = 1;
    end
    if (acc) begin
      c   = (b_start & ~(BL-1)) | ((b_start + k) & (BL-1));
      idx = b_bank * COLS + c;
      if (b_wr) begin
        if (!m) ref_m[idx] = d & ((1 << DW) - 1);
      end else begin
        rq.push_back('{e + CL, ref_m[idx]});
      end
      if (k == BL-1) begin
        b_act = 0;
        if (b_ap) pq.push_back('{e, b_bank});
      end else begin
        b_act = 1; b_k = k + 1;
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr_burst(int bank, int col, bit ap, int seed, logic [BL-1:0] mask);
    for (int k = 0; k < BL; k++) step(k == 0, 1, bank, col, ap, mask[k], seed + k * 17);
  endtask

  task automatic rd_burst(int bank, int col, bit ap, logic [BL-1:0] mask);
    for (int j = 0; j < BL + CL; j++) begin
      int  kk;
      bit  m;
      kk = j - (CL - 2);
      m  = (kk >= 0 && kk < BL) ? mask[kk] : 1'b0;
      step(j == 0, 0, bank, col, ap, m, 0);
    end
  endtask

  // monitor: pops expected read beats and precharge events
  always @(negedge clk) begin
    if (mon_on) begin
      if (rq.size() > 0 && rq[0].due == cyc) begin
        ev_t it;
        bit  exp_oe;
        it = rq.pop_front();
        exp_oe = !dqm_hist[(cyc - 2) % HN];
        chk(dq_oe == exp_oe, "R5 read mask", int'(dq_oe), int'(exp_oe));
        if (exp_oe) chk(dq_out == DW'(it.val), "R4 read data", int'(dq_out), it.val);
        else        chk(dq_out == '0, "R6 masked beat zero", int'(dq_out), 0);
      end else begin
        chk(!dq_oe && dq_out == '0, "R6 idle bus", int'(dq_oe) * 1000 + int'(dq_out), 0);
      end
      if (pq.size() > 0 && pq[0].due == cyc) begin
        ev_t p;
        p = pq.pop_front();
        chk(pre_req && pre_bank == BAW'(p.val), "R7 precharge",
            pre_req ? int'(pre_bank) : -1, p.val);
      end else begin
        chk(!pre_req, "R7 no precharge", int'(pre_req), 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_vld = 0; cmd_wr = 0; cmd_ap = 0; dqm = 0;
    cmd_bank = '0; cmd_col = '0; dq_in = '0;
    for (int i = 0; i < HN; i++) dqm_hist[i] = 0;
    for (int i = 0; i < BANKS*COLS; i++) ref_m[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    phase = "R6";
    chk(!dq_oe && dq_out == '0, "R6 reset bus", int'(dq_oe), 0);
    chk(!pre_req, "R6 reset precharge", int'(pre_req), 0);
    mon_on = 1;

    // R1: fill every location with full aligned bursts
    phase = "R1";
    for (int b = 0; b < BANKS; b++)
      for (int c = 0; c < COLS; c += BL)
        wr_burst(b, c, 0, b * 64 + c * 5 + 1, '0);
    phase = "R4";
    for (int b = 0; b < BANKS; b++)
      for (int c = 0; c < COLS; c += BL)
        rd_burst(b, c, 0, '0);

    // R2: unaligned start wraps inside the block
    phase = "R2";
    wr_burst(2, 6, 0, 200, '0);
    rd_burst(2, 5, 0, '0);
    rd_burst(2, 7, 0, '0);

    // R3: masked write beats leave old data
    phase = "R3";
    wr_burst(1, 8, 0, 90, 4'b0101);
    rd_burst(1, 8, 0, '0);
    wr_burst(1, 13, 0, 31, 4'b1110);
    rd_burst(1, 12, 0, '0);

    // R5: read masks two edges ahead
    phase = "R5";
    rd_burst(3, 0, 0, 4'b1010);
    rd_burst(3, 4, 0, 4'b1111);
    rd_burst(0, 12, 0, 4'b0001);
    rd_burst(0, 2, 0, 4'b0110);

    // R7: auto precharge on write and read
    phase = "R7";
    wr_burst(0, 4, 1, 120, '0);
    idle(2);
    rd_burst(2, 12, 1, '0);
    rd_burst(3, 9, 1, 4'b0010);

    // R8: interrupted read, then interrupted write
    phase = "R8";
    step(1, 0, 1, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 3, 8, 0, 0, 0);
    idle(BL + CL + 2);
    step(1, 1, 0, 0, 1, 0, 33);
    step(0, 0, 0, 0, 0, 0, 44);
    step(1, 0, 0, 0, 0, 0, 0);
    idle(BL + CL + 2);

    // R9: banks hold separate contents
    phase = "R9";
    wr_burst(3, 3, 0, 150, '0);
    rd_burst(2, 3, 0, '0);
    rd_burst(3, 3, 0, '0);
    rd_burst(1, 0, 0, '0);

    idle(BL + CL + 4);
    phase = "R4";
    chk(rq.size() == 0, "R4 all beats seen", rq.size(), 0);
    chk(pq.size() == 0, "R7 all requests seen", pq.size(), 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule